// File: doc/BRIEF.md
# Reference Divider Network

This block derives two phase-comparison reference pulse trains, `fr1_o` and `fr2_o`, from one oscillator clock. A programmable 12-bit main divider produces tap A. Tap A drives a fixed divide-by-4 stage, which produces tap B, and tap B drives a fixed divide-by-25 stage, which produces tap C. A separate programmable 14-bit auxiliary divider, also clocked by the oscillator, produces tap D. Configuration inputs decide which tap drives each output.

The auxiliary-enable input sets the routing. When it is low, the auxiliary divider is stopped, its ratio input is ignored, and `fr2_o` follows tap C. When it is high, `fr2_o` follows tap D. In both cases the 2-bit route code selects the `fr1_o` source. A reference power-down input stops both programmable dividers and the fixed post-chain. A separate system clock output runs at the oscillator rate divided by 3 or by 4, and power-down does not affect it.

Every tap is a pulse one oscillator cycle wide, emitted once per terminal count. All state resets synchronously with an active-low reset.

Top module: `refdiv_network`

## Requirements
- R1: With `route_sel`=2'b01 (bit 1 is S1, bit 0 is S2), `fr1_o` carries tap A. Tap A is a one-cycle pulse whose period is `main_ratio` oscillator cycles, for ratios 16 to 4095.
- R2: With `route_sel`=2'b10, `fr1_o` carries tap B, whose period is 4 times the tap A period.
- R3: Tap C has a period of 100 times the tap A period (divide-by-4, then divide-by-25).
- R4: With `aux_en`=1, `fr2_o` carries tap D. Tap D is a one-cycle pulse whose period is `aux_ratio` cycles, for ratios 16 to 16383.
- R5: With `aux_en`=0, `fr2_o` carries tap C, and `aux_ratio` has no effect on it.
- R6: With `aux_en`=1, `route_sel`=2'b11 routes tap C to `fr1_o`. Code 2'b00 is invalid in both auxiliary modes, and code 2'b11 is invalid when `aux_en`=0. An invalid code holds `fr1_o` low.
- R7: While `ref_pwrdn`=1, `fr1_o` and `fr2_o` stay low. After it returns to 0, the first tap A pulse is seen after `main_ratio` clock edges.
- R8: `sysclk_o` has a period of 3 cycles and is high for 1 cycle when `sysclk_div3`=1. When `sysclk_div3`=0, the period is 4 cycles and it is high for 2.
- R9: During reset all outputs are low. After reset is released, the first tap A pulse is seen after `main_ratio` clock edges.
- R10: A programmed ratio below 16 is treated as 16, for both the main divider and the auxiliary divider.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Synchronous active-low reset |
| main_ratio | input | 12 | Main divider ratio (tap A) |
| aux_ratio | input | 14 | Auxiliary divider ratio (tap D) |
| aux_en | input | 1 | 1: auxiliary divider runs and drives fR2 |
| route_sel | input | 2 | fR1 source code {S1,S2} |
| ref_pwrdn | input | 1 | 1: stop both dividers and the post-chain |
| sysclk_div3 | input | 1 | 1: system clock is osc/3, 0: osc/4 |
| fr1_o | output | 1 | First reference pulse train |
| fr2_o | output | 1 | Second reference pulse train |
| sysclk_o | output | 1 | Divided system clock |

## Verification
The bench measures periods at the ratio extremes. These are the 4095 and 16383 maxima and clamped values such as 5 and 0. A divider with an off-by-one terminal count would show a period one cycle off, and a missing clamp would give a short or stuck period. The bench checks code 2'b11 in both auxiliary modes, because a decoder that ignores `aux_en` would pass tap C when it should hold `fr1_o` low. It checks `fr2_o` with two different `aux_ratio` values while the auxiliary divider is disabled, which catches leakage of tap D into `fr2_o`. It also times the first pulse after reset and after power-down, which exposes a divider that fails to clear its count.

// File: rtl/refdiv_pkg.sv
// Package: shared constants and route code encoding for the reference
// divider network. Assumes the route code is {S1,S2} with S1 in bit 1.
package refdiv_pkg;

    localparam int unsigned REF_MIN_RATIO = 16;

    typedef enum logic [1:0] {
        ROUTE_NONE = 2'b00,
        ROUTE_A    = 2'b01,
        ROUTE_B    = 2'b10,
        ROUTE_C    = 2'b11
    } route_code_e;

endpackage

// File: rtl/refdiv_prog_cnt.sv
// Programmable divider: emits a one-cycle pulse every RATIO enabled cycles.
// Ratios below MIN_RATIO are clamped. Assumes MIN_RATIO >= 2, so pulses
// never touch. When run is low, the count and the pulse are cleared.
module refdiv_prog_cnt #(
    parameter int unsigned W         = 12,
    parameter int unsigned MIN_RATIO = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic [W-1:0] ratio,
    output logic         pulse_o
);
    localparam logic [W-1:0] MIN_R = W'(MIN_RATIO);

    logic [W-1:0] ratio_eff;
    logic [W-1:0] term;
    logic [W-1:0] cnt;

    // Clamp the ratio and derive the terminal count.
    always_comb begin
        ratio_eff = (ratio < MIN_R) ? MIN_R : ratio;
        term      = ratio_eff - 1'b1;
    end

    // Count enabled cycles; pulse and wrap at the terminal count.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt     <= '0;
            pulse_o <= 1'b0;
        end else if (cnt >= term) begin
            cnt     <= '0;
            pulse_o <= 1'b1;
        end else begin
            cnt     <= cnt + 1'b1;
            pulse_o <= 1'b0;
        end
    end

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_o |=> !pulse_o); // R1

endmodule

// File: rtl/refdiv_fixed_stage.sv
// Fixed divider stage: counts input pulses and emits one output pulse,
// delayed one cycle, on every DIV-th input pulse. Assumes the input pulses
// are single-cycle. clear empties the stage.
module refdiv_fixed_stage #(
    parameter int unsigned DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic pulse_i,
    output logic pulse_o
);
    localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt;

    // Count input pulses and fire on the last one of each group.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt     <= '0;
            pulse_o <= 1'b0;
        end else if (pulse_i) begin
            if (cnt == LAST) begin
                cnt     <= '0;
                pulse_o <= 1'b1;
            end else begin
                cnt     <= cnt + 1'b1;
                pulse_o <= 1'b0;
            end
        end else begin
            pulse_o <= 1'b0;
        end
    end

    AST_STAGE_FROM_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_o |-> $past(pulse_i)); // R2

endmodule

// File: rtl/refdiv_sysclk.sv
// System clock divider: runs at the oscillator rate divided by 3 (sel3=1)
// or by 4. The output is high for period/2 cycles, rounded down, at the
// start of each period. The divider is not affected by reference power-down.
module refdiv_sysclk (
    input  logic clk,
    input  logic rst_n,
    input  logic sel3,
    output logic sysclk_o
);
    logic [1:0] cnt;
    logic [1:0] cnt_nx;
    logic [1:0] last;
    logic [1:0] high_len;

    // Next phase and high length for the selected ratio.
    always_comb begin
        last     = sel3 ? 2'd2 : 2'd3;
        high_len = sel3 ? 2'd1 : 2'd2;
        cnt_nx   = (cnt >= last) ? 2'd0 : cnt + 2'd1;
    end

    // Advance the phase and register the output level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt      <= 2'd0;
            sysclk_o <= 1'b0;
        end else begin
            cnt      <= cnt_nx;
            sysclk_o <= (cnt_nx < high_len);
        end
    end

    AST_SYSCLK_DIV3_NARROW: assert property (@(posedge clk) disable iff (!rst_n)
        (sel3 && $past(sel3) && $past(sel3, 2) && sysclk_o) |-> !$past(sysclk_o)); // R8

endmodule

// File: rtl/refdiv_network.sv
// Reference divider network top. Main divider -> tap A; fixed post-chain
// stages give taps B and C; auxiliary divider -> tap D. Route logic picks
// the fR1 and fR2 sources. Assumes the configuration inputs are quasi-static
// and synchronous to clk.
module refdiv_network
    import refdiv_pkg::*;
#(
    parameter int unsigned MAIN_W    = 12,
    parameter int unsigned AUX_W     = 14,
    parameter int unsigned POST_DIV1 = 4,
    parameter int unsigned POST_DIV2 = 25
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MAIN_W-1:0] main_ratio,
    input  logic [AUX_W-1:0]  aux_ratio,
    input  logic              aux_en,
    input  logic [1:0]        route_sel,
    input  logic              ref_pwrdn,
    input  logic              sysclk_div3,
    output logic              fr1_o,
    output logic              fr2_o,
    output logic              sysclk_o
);
    localparam int unsigned NSTAGE = 2;

    function automatic int unsigned stage_div(input int unsigned idx);
        return (idx == 0) ? POST_DIV1 : POST_DIV2;
    endfunction

    logic              main_run;
    logic              aux_run;
    logic [NSTAGE:0]   chain;   // chain[0]=A, chain[1]=B, chain[2]=C
    logic              tap_d;
    route_code_e       code;

    // Run enables for the two programmable dividers.
    always_comb begin
        main_run = !ref_pwrdn;
        aux_run  = aux_en && !ref_pwrdn;
    end

    refdiv_prog_cnt #(.W(MAIN_W), .MIN_RATIO(REF_MIN_RATIO)) u_main (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (main_run),
        .ratio   (main_ratio),
        .pulse_o (chain[0])
    );

    for (genvar gi = 0; gi < NSTAGE; gi++) begin : g_post
        refdiv_fixed_stage #(.DIV(stage_div(gi))) u_stage (
            .clk     (clk),
            .rst_n   (rst_n),
            .clear   (ref_pwrdn),
            .pulse_i (chain[gi]),
            .pulse_o (chain[gi+1])
        );
    end

    refdiv_prog_cnt #(.W(AUX_W), .MIN_RATIO(REF_MIN_RATIO)) u_aux (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (aux_run),
        .ratio   (aux_ratio),
        .pulse_o (tap_d)
    );

    refdiv_sysclk u_sysclk (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel3     (sysclk_div3),
        .sysclk_o (sysclk_o)
    );

    // Route the taps to fR1 (per code and aux mode) and to fR2.
    always_comb begin
        code = route_code_e'(route_sel);
        unique case (code)
            ROUTE_A:    fr1_o = chain[0];
            ROUTE_B:    fr1_o = chain[1];
            ROUTE_C:    fr1_o = aux_en ? chain[2] : 1'b0;
            default:    fr1_o = 1'b0;
        endcase
        fr2_o = aux_en ? tap_d : chain[NSTAGE];
    end

    AST_PWRDN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_pwrdn && $past(ref_pwrdn) && $past(ref_pwrdn, 2)) |-> (!fr1_o && !fr2_o)); // R7

    AST_AUX_OFF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (!aux_en && $past(!aux_en)) |-> !tap_d); // R5

endmodule

// File: tb/refdiv_network_bench.sv
`timescale 1ns/1ps
module refdiv_network_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] main_ratio = 12'd20;
    logic [13:0] aux_ratio = 14'd37;
    logic        aux_en = 1'b0;
    logic [1:0]  route_sel = 2'b01;
    logic        ref_pwrdn = 1'b0;
    logic        sysclk_div3 = 1'b0;
    logic        fr1_o, fr2_o, sysclk_o;

    int nvec = 0;
    int nbad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    refdiv_network u_refdiv_network (
        .clk(clk), .rst_n(rst_n), .main_ratio(main_ratio), .aux_ratio(aux_ratio),
        .aux_en(aux_en), .route_sel(route_sel), .ref_pwrdn(ref_pwrdn),
        .sysclk_div3(sysclk_div3), .fr1_o(fr1_o), .fr2_o(fr2_o), .sysclk_o(sysclk_o)
    );

    function automatic logic sig(input int which);
        case (which)
            0: return fr1_o;
            1: return fr2_o;
            default: return sysclk_o;
        endcase
    endfunction

    task automatic check(input string req, input int act, input int exp);
        nvec++;
        if (act != exp) begin
            nbad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Cycles between two successive rising edges of a signal (-1 on timeout).
    task automatic meas(input int which, input int limit, output int per);
        logic prev, cur;
        int n;
        bit found;
        per = -1;
        found = 1'b0;
        @(negedge clk);
        prev = sig(which);
        for (int i = 0; i < limit; i++) begin
            @(negedge clk);
            cur = sig(which);
            if (cur && !prev) begin found = 1'b1; break; end
            prev = cur;
        end
        if (!found) return;
        prev = 1'b1;
        n = 0;
        for (int i = 0; i < limit; i++) begin
            @(negedge clk);
            n++;
            cur = sig(which);
            if (cur && !prev) begin per = n; return; end
            prev = cur;
        end
    endtask

    // Number of sampled cycles in which the signal is high over a window.
    task automatic count_high(input int which, input int len, output int hits);
        hits = 0;
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            if (sig(which)) hits++;
        end
    endtask

    // Negedges after a release until fr1 is first seen high.
    task automatic first_pulse(input int limit, output int k);
        k = 0;
        for (int i = 0; i < limit; i++) begin
            @(negedge clk);
            k++;
            if (fr1_o) return;
        end
        k = -1;
    endtask

    task automatic t_reset;
        int k, p;
        main_ratio = 12'd20; route_sel = 2'b01; aux_en = 1'b1; aux_ratio = 14'd37;
        rst_n = 1'b0;
        repeat (5) @(negedge clk);
        check("R9 fr1 in reset", fr1_o, 0);
        check("R9 fr2 in reset", fr2_o, 0);
        check("R9 sysclk in reset", sysclk_o, 0);
        rst_n = 1'b1;
        first_pulse(100, k);
        check("R9 first pulse after reset", k, 20);
        @(negedge clk);
        check("R1 pulse one cycle wide", fr1_o, 0);
        meas(0, 200, p);
        check("R1 tap A period 20", p, 20);
    endtask

    task automatic t_tap_b;
        int p;
        route_sel = 2'b10; main_ratio = 12'd20;
        meas(0, 400, p);
        check("R2 tap B period 80", p, 80);
    endtask

    task automatic t_tap_c;
        int p;
        aux_en = 1'b1; route_sel = 2'b11; main_ratio = 12'd20;
        meas(0, 5000, p);
        check("R3 R6 tap C period 2000", p, 2000);
    endtask

    task automatic t_aux;
        int p;
        aux_en = 1'b1; aux_ratio = 14'd37;
        meas(1, 200, p);
        check("R4 tap D period 37", p, 37);
        aux_ratio = 14'd16383;
        meas(1, 40000, p);
        check("R4 tap D period 16383", p, 16383);
    endtask

    task automatic t_aux_off;
        int p;
        aux_en = 1'b0; main_ratio = 12'd16; aux_ratio = 14'd40;
        meas(1, 4000, p);
        check("R5 fr2 from tap C (aux 40)", p, 1600);
        aux_ratio = 14'd1000;
        meas(1, 4000, p);
        check("R5 fr2 from tap C (aux 1000)", p, 1600);
    endtask

    task automatic t_invalid;
        int h;
        main_ratio = 12'd16;
        aux_en = 1'b0; route_sel = 2'b11;
        count_high(0, 3500, h);
        check("R6 code 11 aux off holds fr1 low", h, 0);
        aux_en = 1'b1; route_sel = 2'b00;
        count_high(0, 3500, h);
        check("R6 code 00 holds fr1 low", h, 0);
    endtask

    task automatic t_clamp;
        int p;
        aux_en = 1'b1; route_sel = 2'b01;
        main_ratio = 12'd5;
        meas(0, 200, p);
        check("R10 main ratio 5 clamps to 16", p, 16);
        main_ratio = 12'd0;
        meas(0, 200, p);
        check("R10 main ratio 0 clamps to 16", p, 16);
        aux_ratio = 14'd3;
        meas(1, 200, p);
        check("R10 aux ratio 3 clamps to 16", p, 16);
    endtask

    task automatic t_max;
        int p;
        route_sel = 2'b01; main_ratio = 12'd4095;
        meas(0, 10000, p);
        check("R1 tap A period 4095", p, 4095);
    endtask

    task automatic t_pwrdn;
        int h, k;
        main_ratio = 12'd20; aux_ratio = 14'd37; aux_en = 1'b1; route_sel = 2'b01;
        @(negedge clk);
        ref_pwrdn = 1'b1;
        @(negedge clk);
        count_high(0, 300, h);
        check("R7 fr1 low in power-down", h, 0);
        count_high(1, 300, h);
        check("R7 fr2 low in power-down", h, 0);
        ref_pwrdn = 1'b0;
        first_pulse(100, k);
        check("R7 first pulse after power-down", k, 20);
    endtask

    task automatic t_sysclk;
        int p, h;
        sysclk_div3 = 1'b1;
        repeat (8) @(negedge clk);
        meas(2, 20, p);
        check("R8 sysclk period div3", p, 3);
        count_high(2, 12, h);
        check("R8 sysclk high cycles div3", h, 4);
        sysclk_div3 = 1'b0;
        repeat (8) @(negedge clk);
        meas(2, 20, p);
        check("R8 sysclk period div4", p, 4);
        count_high(2, 12, h);
        check("R8 sysclk high cycles div4", h, 6);
    endtask

    initial begin
        t_reset();
        t_tap_b();
        t_tap_c();
        t_aux();
        t_aux_off();
        t_invalid();
        t_clamp();
        t_max();
        t_pwrdn();
        t_sysclk();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            nvec++;
            nbad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
            $finish;
        end
    end

endmodule